// File: doc/BRIEF.md
# VLAN Table Apply Sequencer

This controller copies a software-held VLAN membership table into a switch's VLAN translation unit. It drives a generic register read/write master port, and while it walks the table it works out, for every switch port, the set of ports that port may forward to. A single start pulse launches one complete apply run. The run ends with a one-cycle done pulse, or with a held timeout error if the translation unit never becomes ready.

Before every command the sequencer polls the unit's command register. It waits until the active flag is clear, and it gives up after a bounded number of retries that are spaced a parameterised number of clock cycles apart. A run always begins with a flush command. When VLAN mode is enabled, the sequencer then visits every table entry in ascending index order, skips empty entries, and loads each populated entry with its VID. It also merges the entry's members into the destination masks. When VLAN mode is disabled, no entries are loaded: every port is isolated except for a path to and from the CPU port.

Top module: `vlan_apply_seq`

## Requirements
- R1: Before each command write, the block reads the command register (address `CMD_ADDR`) until bit 31 (active) reads 0. Consecutive reads are separated by `POLL_GAP` idle cycles. If the last of `MAX_RETRY`+1 reads still shows bit 31 set, the run aborts.
- R2: The first write of every run goes to `CMD_ADDR` with bit 31 set and opcode bits [3:0] = 1 (flush).
- R3: A load is a write to `DATA_ADDR` followed directly by a write to `CMD_ADDR`. The data word holds the entry's member bits in [NUM_PORTS-1:0] (field [9:0]), bit 11 = 1 and all other bits 0. The command word holds bit 31 = 1, the VID in [27:16] and opcode [3:0] = 2 (load), with all other bits 0.
- R4: In VLAN mode, entries are visited in index order from 0 to NUM_VLANS-1. An entry whose membership is all zero produces no bus transaction.
- R5: In VLAN mode, when an entry is reached, each member port p ORs into `port_mask[p]` the entry's members with bit p cleared. The masks start each run at zero. A port never carries its own bit.
- R6: With VLAN mode off, after the flush no load is issued. Each non-CPU port's mask then equals only the CPU port bit, and the CPU port's mask holds every other port.
- R7: `busy` is high from the cycle after start until the run ends. `done` pulses for exactly one cycle after the last entry (or after the flush when VLAN mode is off).
- R8: On timeout the block issues no further transactions and does not pulse `done`. `tmo_err` stays high until the next accepted start clears it.
- R9: While `reg_req` is high without `reg_ack`, the signals `reg_we`, `reg_addr` and `reg_wdata` stay unchanged.
- R10: After reset, `reg_req`, `busy`, `done` and `tmo_err` are low and all port masks are zero.
- R11: A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an apply run |
| vlan_en | input | 1 | VLAN mode, sampled at start |
| cpu_port | input | $clog2(NUM_PORTS) | Index of the CPU port, sampled at start |
| member_tbl | input | NUM_VLANS*NUM_PORTS | Membership of entry j at [j*NUM_PORTS +: NUM_PORTS] |
| vid_tbl | input | NUM_VLANS*VID_W | VID of entry j at [j*VID_W +: VID_W] |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | One-cycle completion of the pending access |
| reg_rdata | input | 32 | Read data, valid with reg_ack |
| port_mask | output | NUM_PORTS*NUM_PORTS | Destination mask of port p at [p*NUM_PORTS +: NUM_PORTS] |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle successful completion pulse |
| tmo_err | output | 1 | Held timeout error |

## Verification
The assertions take three things for granted. First, `reg_ack` rises only as a one-cycle answer to a pending `reg_req`. Second, the membership table, VID table, `cpu_port` and `vlan_en` stay constant from a start until that run ends. Third, `cpu_port` names an existing port. The stimulus keeps to these by building the tables before each run and leaving them untouched until done or the error appears. Its register responder acknowledges only an outstanding request, after a chosen latency, for exactly one cycle. The responder also decides how many busy reads each poll sees, or when the unit becomes permanently busy, which exercises the retry bound on both sides of its limit.

// File: rtl/vlan_apply_pkg.sv
package vlan_apply_pkg;

   localparam int          ACTIVE_BIT   = 31;
   localparam int          VALID_BIT    = 11;
   localparam int          MEMBER_FLD_W = 10;
   localparam int          VID_FLD_W    = 12;
   localparam logic [3:0]  OP_FLUSH     = 4'd1;
   localparam logic [3:0]  OP_LOAD      = 4'd2;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FL_POLL,
      SQ_FL_CMD,
      SQ_SCAN,
      SQ_LD_POLL,
      SQ_LD_DATA,
      SQ_LD_CMD
   } seq_state_t;

   typedef enum logic [1:0] {
      PL_IDLE,
      PL_READ,
      PL_GAP
   } poll_state_t;

   // command word: active flag, VID field, opcode
   function automatic logic [31:0] cmd_word(input logic [3:0] op,
                                            input logic [VID_FLD_W-1:0] vid);
      return {1'b1, 3'b000, vid, 12'h000, op};
   endfunction

   // data word: valid flag plus member field
   function automatic logic [31:0] data_word(input logic [MEMBER_FLD_W-1:0] mem);
      return {20'h00000, 1'b1, 1'b0, mem};
   endfunction

endpackage

// File: rtl/vtu_busy_poll.sv
module vtu_busy_poll
   import vlan_apply_pkg::*;
#(
   parameter int MAX_RETRY = 20,
   parameter int POLL_GAP  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic ack,
   input  logic active_flag,
   output logic rd_req,
   output logic ready,
   output logic expired
);

   localparam int RW = $clog2(MAX_RETRY + 1) < 1 ? 1 : $clog2(MAX_RETRY + 1);
   localparam int GW = $clog2(POLL_GAP + 1) < 1 ? 1 : $clog2(POLL_GAP + 1);

   poll_state_t    st;
   logic [RW-1:0]  tries;
   logic [GW-1:0]  gap_cnt;

   assign rd_req = (st == PL_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= PL_IDLE;
         tries   <= '0;
         gap_cnt <= '0;
         ready   <= 1'b0;
         expired <= 1'b0;
      end else begin
         ready   <= 1'b0;
         expired <= 1'b0;
         case (st)
            PL_IDLE: begin
               if (go) begin
                  tries <= '0;
                  st    <= PL_READ;
               end
            end
            PL_READ: begin
               if (ack) begin
                  if (!active_flag) begin
                     ready <= 1'b1;
                     st    <= PL_IDLE;
                  end else if (tries == RW'(MAX_RETRY)) begin
                     expired <= 1'b1;
                     st      <= PL_IDLE;
                  end else begin
                     tries   <= tries + 1'b1;
                     gap_cnt <= '0;
                     st      <= PL_GAP;
                  end
               end
            end
            PL_GAP: begin
               if (gap_cnt == GW'(POLL_GAP - 1)) st <= PL_READ;
               else                              gap_cnt <= gap_cnt + 1'b1;
            end
            default: st <= PL_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vtu_mask_build.sv
module vtu_mask_build #(
   parameter int NUM_PORTS = 6,
   parameter int PIW       = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic                           acc,
   input  logic [NUM_PORTS-1:0]           acc_members,
   input  logic                           solo,
   input  logic [PIW-1:0]                 cpu,
   output logic [NUM_PORTS*NUM_PORTS-1:0] masks
);

   localparam logic [NUM_PORTS-1:0] ALL_PORTS = {NUM_PORTS{1'b1}};

   logic [NUM_PORTS-1:0] cpu_bit;
   assign cpu_bit = NUM_PORTS'(1) << cpu;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [NUM_PORTS-1:0] SELF = NUM_PORTS'(1) << p;
      logic [NUM_PORTS-1:0] m_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= '0;
         end else if (clr) begin
            m_q <= '0;
         end else if (acc && acc_members[p]) begin
            m_q <= m_q | (acc_members & ~SELF);
         end else if (solo) begin
            if (cpu == PIW'(p)) m_q <= ALL_PORTS & ~SELF;
            else                m_q <= cpu_bit;
         end
      end

      assign masks[p*NUM_PORTS +: NUM_PORTS] = m_q;
   end

endmodule

// File: rtl/vlan_apply_seq.sv
module vlan_apply_seq
   import vlan_apply_pkg::*;
#(
   parameter int               NUM_PORTS = 6,
   parameter int               NUM_VLANS = 128,
   parameter int               VID_W     = 12,
   parameter int               MAX_RETRY = 20,
   parameter int               POLL_GAP  = 8,
   parameter int               ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'h0040,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0044
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           vlan_en,
   input  logic [$clog2(NUM_PORTS)-1:0]   cpu_port,
   input  logic [NUM_VLANS*NUM_PORTS-1:0] member_tbl,
   input  logic [NUM_VLANS*VID_W-1:0]     vid_tbl,
   output logic                           reg_req,
   output logic                           reg_we,
   output logic [ADDR_W-1:0]              reg_addr,
   output logic [31:0]                    reg_wdata,
   input  logic                           reg_ack,
   input  logic [31:0]                    reg_rdata,
   output logic [NUM_PORTS*NUM_PORTS-1:0] port_mask,
   output logic                           busy,
   output logic                           done,
   output logic                           tmo_err
);

   localparam int IDX_W = $clog2(NUM_VLANS);
   localparam int PIW   = $clog2(NUM_PORTS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VLANS - 1);

   if (NUM_PORTS < 2 || NUM_PORTS > MEMBER_FLD_W) begin : g_bad_ports
      $error("NUM_PORTS must lie in 2..10");
   end
   if (NUM_VLANS < 2) begin : g_bad_vlans
      $error("NUM_VLANS must be at least 2");
   end
   if (VID_W < 1 || VID_W > VID_FLD_W) begin : g_bad_vid
      $error("VID_W must lie in 1..12");
   end
   if (POLL_GAP < 1 || MAX_RETRY < 0) begin : g_bad_poll
      $error("POLL_GAP must be >= 1 and MAX_RETRY >= 0");
   end

   seq_state_t        state;
   logic [IDX_W-1:0]  idx;
   logic              vlan_q;
   logic [PIW-1:0]    cpu_q;
   logic              poll_go;
   logic              poll_rd, poll_ok, poll_tmo;
   logic              done_q, err_q;

   logic [NUM_PORTS-1:0] cur_mem;
   logic [VID_W-1:0]     cur_vid;
   logic                 last_entry;
   logic                 wr_req;
   logic [ADDR_W-1:0]    wr_addr;
   logic [31:0]          wr_data;
   logic                 m_clr, m_acc, m_solo;
   logic                 unused_rdata;

   assign cur_mem    = member_tbl[idx*NUM_PORTS +: NUM_PORTS];
   assign cur_vid    = vid_tbl[idx*VID_W +: VID_W];
   assign last_entry = (idx == LAST_IDX);
   assign unused_rdata = ^reg_rdata[30:0];

   // ---------------- busy-flag poller ----------------
   vtu_busy_poll #(
      .MAX_RETRY (MAX_RETRY),
      .POLL_GAP  (POLL_GAP)
   ) u_poll (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (poll_go),
      .ack         (reg_ack),
      .active_flag (reg_rdata[ACTIVE_BIT]),
      .rd_req      (poll_rd),
      .ready       (poll_ok),
      .expired     (poll_tmo)
   );

   // ---------------- write path ----------------
   always_comb begin
      wr_req  = 1'b0;
      wr_addr = CMD_ADDR;
      wr_data = '0;
      case (state)
         SQ_FL_CMD: begin
            wr_req  = 1'b1;
            wr_data = cmd_word(OP_FLUSH, '0);
         end
         SQ_LD_DATA: begin
            wr_req  = 1'b1;
            wr_addr = DATA_ADDR;
            wr_data = data_word(MEMBER_FLD_W'(cur_mem));
         end
         SQ_LD_CMD: begin
            wr_req  = 1'b1;
            wr_data = cmd_word(OP_LOAD, VID_FLD_W'(cur_vid));
         end
         default: ;
      endcase
   end

   assign reg_req   = wr_req | poll_rd;
   assign reg_we    = wr_req;
   assign reg_addr  = wr_req ? wr_addr : CMD_ADDR;
   assign reg_wdata = wr_req ? wr_data : 32'h0;

   // ---------------- mask builder ----------------
   assign m_clr  = (state == SQ_IDLE) && start;
   assign m_acc  = (state == SQ_SCAN) && (cur_mem != '0);
   assign m_solo = (state == SQ_FL_CMD) && reg_ack && !vlan_q;

   vtu_mask_build #(
      .NUM_PORTS (NUM_PORTS),
      .PIW       (PIW)
   ) u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (m_clr),
      .acc         (m_acc),
      .acc_members (cur_mem),
      .solo        (m_solo),
      .cpu         (cpu_q),
      .masks       (port_mask)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         idx     <= '0;
         vlan_q  <= 1'b0;
         cpu_q   <= '0;
         poll_go <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         poll_go <= 1'b0;
         done_q  <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  vlan_q  <= vlan_en;
                  cpu_q   <= cpu_port;
                  err_q   <= 1'b0;
                  poll_go <= 1'b1;
                  state   <= SQ_FL_POLL;
               end
            end
            SQ_FL_POLL: begin
               if (poll_tmo) begin
                  err_q <= 1'b1;
                  state <= SQ_IDLE;
               end else if (poll_ok) begin
                  state <= SQ_FL_CMD;
               end
            end
            SQ_FL_CMD: begin
               if (reg_ack) begin
                  if (vlan_q) begin
                     idx   <= '0;
                     state <= SQ_SCAN;
                  end else begin
                     done_q <= 1'b1;
                     state  <= SQ_IDLE;
                  end
               end
            end
            SQ_SCAN: begin
               if (cur_mem != '0) begin
                  poll_go <= 1'b1;
                  state   <= SQ_LD_POLL;
               end else if (last_entry) begin
                  done_q <= 1'b1;
                  state  <= SQ_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            SQ_LD_POLL: begin
               if (poll_tmo) begin
                  err_q <= 1'b1;
                  state <= SQ_IDLE;
               end else if (poll_ok) begin
                  state <= SQ_LD_DATA;
               end
            end
            SQ_LD_DATA: begin
               if (reg_ack) state <= SQ_LD_CMD;
            end
            SQ_LD_CMD: begin
               if (reg_ack) begin
                  if (last_entry) begin
                     done_q <= 1'b1;
                     state  <= SQ_IDLE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= SQ_SCAN;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = (state != SQ_IDLE);
   assign done    = done_q;
   assign tmo_err = err_q;

endmodule

// File: rtl/vlan_apply_chk.sv
module vlan_apply_chk #(
   parameter int               NUM_PORTS = 6,
   parameter int               ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'h0040,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0044
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           start,
   input logic                           reg_req,
   input logic                           reg_we,
   input logic [ADDR_W-1:0]              reg_addr,
   input logic [31:0]                    reg_wdata,
   input logic                           reg_ack,
   input logic [31:0]                    reg_rdata,
   input logic [NUM_PORTS*NUM_PORTS-1:0] port_mask,
   input logic                           done,
   input logic                           tmo_err
);

   // R9
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) &&
                                 $stable(reg_addr) && $stable(reg_wdata)));

   // R1
   retry_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_ack && !reg_we && reg_rdata[31]) |=> !reg_req);

   // R2
   cmd_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_we && reg_addr == CMD_ADDR) |-> reg_wdata[31]);

   // R3
   data_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_we && reg_addr == DATA_ADDR) |-> reg_wdata[11]);

   // R3
   load_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_ack && reg_we && reg_addr == DATA_ADDR) |=>
         (reg_req && reg_we && reg_addr == CMD_ADDR && reg_wdata[3:0] == 4'd2));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tmo_err);

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_err && !start) |=> tmo_err);

   // R8
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_err && !start) |=> !reg_req);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_self
      // R5
      no_self_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !port_mask[p*NUM_PORTS + p]);
   end

endmodule

bind vlan_apply_seq vlan_apply_chk #(
   .NUM_PORTS (NUM_PORTS),
   .ADDR_W    (ADDR_W),
   .CMD_ADDR  (CMD_ADDR),
   .DATA_ADDR (DATA_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .reg_req   (reg_req),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_ack   (reg_ack),
   .reg_rdata (reg_rdata),
   .port_mask (port_mask),
   .done      (done),
   .tmo_err   (tmo_err)
);

// File: tb/sim_vlan_apply_seq.sv
module sim_vlan_apply_seq;

   localparam int CLK_PERIOD = 10;
   localparam int NP  = 6;
   localparam int NV  = 128;
   localparam int VW  = 12;
   localparam int MR  = 20;
   localparam int GAP = 3;
   localparam logic [15:0] CMD_A  = 16'h0040;
   localparam logic [15:0] DATA_A = 16'h0044;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic vlan_en = 1'b0;
   logic [2:0] cpu_port = '0;
   logic [NV*NP-1:0] member_tbl;
   logic [NV*VW-1:0] vid_tbl;
   logic reg_req, reg_we, reg_ack;
   logic [15:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [NP*NP-1:0] port_mask;
   logic busy, done, tmo_err;

   logic [NP-1:0] mem_t [NV];
   logic [VW-1:0] vid_t [NV];

   always_comb begin
      for (int j = 0; j < NV; j++) begin
         member_tbl[j*NP +: NP] = mem_t[j];
         vid_tbl[j*VW +: VW]    = vid_t[j];
      end
   end

   always #(CLK_PERIOD/2) clk = ~clk;

   vlan_apply_seq #(
      .NUM_PORTS (NP), .NUM_VLANS (NV), .VID_W (VW),
      .MAX_RETRY (MR), .POLL_GAP (GAP), .ADDR_W (16),
      .CMD_ADDR (CMD_A), .DATA_ADDR (DATA_A)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .start (start), .vlan_en (vlan_en),
      .cpu_port (cpu_port), .member_tbl (member_tbl), .vid_tbl (vid_tbl),
      .reg_req (reg_req), .reg_we (reg_we), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_ack (reg_ack), .reg_rdata (reg_rdata),
      .port_mask (port_mask), .busy (busy), .done (done), .tmo_err (tmo_err)
   );

   typedef struct {
      logic        we;
      logic [15:0] addr;
      logic [31:0] data;
      int          rq;
   } txn_t;

   txn_t exp_q [$];
   logic [NP-1:0] em [NP];

   int n_chk = 0, n_bad = 0;
   int lat = 0, busy_n = 0, stuck_w = 1 << 30;
   int wcnt = 0, rd_since = 0, wait_c = 0;

   // register responder plus per-transaction comparison against the model
   initial reg_ack = 1'b0;
   initial reg_rdata = '0;
   always @(negedge clk) begin
      if (reg_ack) begin
         reg_ack = 1'b0;
      end else if (rst_n && reg_req) begin
         if (wait_c < lat) begin
            wait_c++;
         end else begin
            wait_c  = 0;
            reg_ack = 1'b1;
            if (!reg_we) begin
               reg_rdata = ((wcnt >= stuck_w) || (rd_since < busy_n)) ?
                           (32'h8000_0000 | 32'($urandom_range(0, 255))) :
                           32'($urandom_range(0, 255));
               rd_since++;
            end else begin
               rd_since = 0;
               wcnt++;
            end
            n_chk++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL R8 unexpected access we=%0b addr=%h data=%h, expected none",
                        reg_we, reg_addr, reg_wdata);
            end else begin
               txn_t e;
               e = exp_q.pop_front();
               if (e.we !== reg_we || e.addr !== reg_addr ||
                   (e.we && e.data !== reg_wdata)) begin
                  n_bad++;
                  $display("FAIL R%0d access we=%0b addr=%h data=%h, expected we=%0b addr=%h data=%h",
                           e.rq, reg_we, reg_addr, reg_wdata, e.we, e.addr, e.data);
               end
            end
         end
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // behavioural model of one poll; returns 0 on abort
   function automatic bit model_poll(input int writes);
      int nb;
      nb = (writes >= stuck_w) ? 1000 : busy_n;
      if (nb > MR) begin
         for (int k = 0; k <= MR; k++) exp_q.push_back('{1'b0, CMD_A, 32'h0, 1}); // R1
         return 1'b0;
      end
      for (int k = 0; k <= nb; k++) exp_q.push_back('{1'b0, CMD_A, 32'h0, 1});
      return 1'b1;
   endfunction

   task automatic run_case(input bit ven, input int cpu, input int bn,
                           input int sw, input int l, input bit restart_mid,
                           input string name);
      int writes = 0;
      bit aborted = 0;
      int got_done = 0;
      int cyc = 0;
      logic [NP-1:0] cpub;
      exp_q.delete();
      for (int p = 0; p < NP; p++) em[p] = '0;
      busy_n = bn; stuck_w = sw; lat = l;
      wcnt = 0; rd_since = 0; wait_c = 0;
      vlan_en = ven; cpu_port = 3'(cpu);
      cpub = NP'(1) << cpu;
      if (!model_poll(writes)) aborted = 1;
      else begin
         exp_q.push_back('{1'b1, CMD_A, 32'h8000_0001, 2}); // R2 flush
         writes++;
         if (ven) begin
            for (int j = 0; j < NV && !aborted; j++) begin
               if (mem_t[j] != '0) begin // R4 skip empty
                  for (int p = 0; p < NP; p++)
                     if (mem_t[j][p]) em[p] |= mem_t[j] & ~(NP'(1) << p); // R5
                  if (!model_poll(writes)) aborted = 1;
                  else begin
                     exp_q.push_back('{1'b1, DATA_A, 32'h800 | 32'(mem_t[j]), 3}); // R3
                     exp_q.push_back('{1'b1, CMD_A,
                        32'h8000_0002 | (32'(vid_t[j]) << 16), 3});
                     writes += 2;
                  end
               end
            end
         end else begin
            for (int p = 0; p < NP; p++)
               em[p] = (p == cpu) ? ({NP{1'b1}} & ~cpub) : cpub; // R6
         end
      end

      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy === 1'b1, "R7", {name, " busy after start"}, busy, 1);
      check(tmo_err === 1'b0, "R8", {name, " error cleared by start"}, tmo_err, 0);
      while (got_done == 0 && !tmo_err && cyc < 30000) begin
         if (done) got_done++;
         @(negedge clk);
         cyc++;
         if (restart_mid && cyc == 10) start = 1'b1;   // R11
         if (restart_mid && cyc == 11) start = 1'b0;
      end
      if (done) got_done++;
      check(cyc < 30000, "R7", {name, " run finished"}, cyc, 30000);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (done) got_done++;
      end
      check(exp_q.size() == 0, "R4", {name, " accesses outstanding"}, exp_q.size(), 0);
      check(got_done == (aborted ? 0 : 1), "R7", {name, " done pulses"}, got_done, aborted ? 0 : 1);
      check(tmo_err === aborted, "R8", {name, " error flag"}, tmo_err, aborted);
      check(busy === 1'b0, "R7", {name, " idle at end"}, busy, 0);
      for (int p = 0; p < NP; p++)
         check(port_mask[p*NP +: NP] === em[p], ven ? "R5" : "R6",
               $sformatf("%s mask port %0d", name, p), port_mask[p*NP +: NP], em[p]);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int j = 0; j < NV; j++) begin mem_t[j] = '0; vid_t[j] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(reg_req === 1'b0, "R10", "req after reset", reg_req, 0);
      check(busy === 1'b0 && done === 1'b0, "R10", "busy/done after reset", {busy, done}, 0);
      check(tmo_err === 1'b0, "R10", "error after reset", tmo_err, 0);
      check(port_mask === '0, "R10", "masks after reset", port_mask, 0);

      // R6 VLAN off, two CPU positions
      run_case(1'b0, 0, 0, 1 << 30, 0, 1'b0, "off_cpu0");
      run_case(1'b0, 5, 3, 1 << 30, 2, 1'b0, "off_cpu5");

      // R3 R4 R5 sparse table incl. first and last entry
      mem_t[0] = 6'b000011;   vid_t[0]   = 12'h001;
      mem_t[5] = 6'b100110;   vid_t[5]   = 12'hABC;
      mem_t[127] = 6'b011000; vid_t[127] = 12'hFFE;
      run_case(1'b1, 0, 2, 1 << 30, 1, 1'b0, "sparse");

      // R11 restart pulse during a run is ignored
      run_case(1'b1, 0, 1, 1 << 30, 0, 1'b1, "restart_mid");

      // R4 empty table: flush only
      for (int j = 0; j < NV; j++) mem_t[j] = '0;
      run_case(1'b1, 2, 0, 1 << 30, 0, 1'b0, "empty");

      // R5 dense pseudo-random table
      for (int j = 0; j < NV; j++) begin
         mem_t[j] = ($urandom_range(0, 3) == 0) ? '0 : NP'($urandom);
         vid_t[j] = VW'($urandom);
      end
      run_case(1'b1, 1, 0, 1 << 30, 0, 1'b0, "dense");

      // R1 boundary: exactly MR busy reads still succeeds
      run_case(1'b0, 3, MR, 1 << 30, 0, 1'b0, "retry_limit");
      // R1 R8 busy forever before flush
      run_case(1'b1, 0, 0, 0, 1, 1'b0, "stuck_flush");
      // R8 becomes stuck before the second load
      run_case(1'b1, 0, 0, 3, 0, 1'b0, "stuck_load");
      repeat (20) @(negedge clk);
      check(tmo_err === 1'b1, "R8", "error held while idle", tmo_err, 1);
      // recovery: next start clears the error
      run_case(1'b1, 4, 1, 1 << 30, 1, 1'b0, "recover");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule